// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write a bank of byte-wide registers over a serial link. The link has four wires: an active-low select, a serial clock that idles high, a host-to-slave data line and a slave-to-host data line. The slave samples host data on rising clock edges and changes its own data on falling clock edges. A frame begins when select goes low. Its first byte is a command byte, and the data bytes follow, most significant bit first. A frame can carry any number of data bytes until select rises again. An optional three-wire mode sends read data back over the host-to-slave line, so that one shared pin carries both directions.

All serial inputs pass through a synchronizer into the system clock domain. Edges of the serial clock are detected there, so the register-file side sees plain single-cycle strobes in the system clock domain. The register file supplies read data combinationally for the address shown in the cycle that the read strobe is high. A command byte holds three things: a read flag, an auto-increment flag and a 6-bit register address. Pad drivers are represented by separate output-enable signals.

Top module: `spi_reg_slave`

## Requirements
- R1: The command byte is the first byte of a frame. Its first bit (bit 7) is the read flag, where 1 means read and 0 means write. Its second bit (bit 6) is the auto-increment flag. Bits 5..0 give the register address, most significant bit first.
- R2: A single-byte write frame takes 16 rising clock edges. It produces exactly one `rf_we` pulse, with `rf_addr` equal to the command address and `rf_wdata` equal to the data byte.
- R3: In a read frame, `rf_rdata` is captured at the read strobe. It is shifted out most significant bit first, and a new bit is presented after each falling serial clock edge so that the host can sample it on the next rising edge.
- R4: When the auto-increment flag is 1, the address steps by one after each completed data byte and wraps from 63 to 0. This holds for both reads and writes.
- R5: When the auto-increment flag is 0, every data byte of the frame uses the command address.
- R6: A read frame pulses `rf_re` once when the command byte completes and once after each completed data byte. The second pulse uses the address of the next byte.
- R7: If select rises before a data byte is complete, the partial byte is discarded and no `rf_we` pulse is produced for it.
- R8: `spi_sdo_oe` is 0 whenever no frame is active. In four-wire mode it is 1 during a frame.
- R9: In three-wire mode (`three_wire`=1), `spi_sdo_oe` stays 0. `spi_sdi_oe` is 1 only during the data phase of a read frame, and the read data then appears on `spi_sdi_out`.
- R10: `rf_we` and `rf_re` are never high in the same cycle, and each pulse lasts one clock cycle.
- R11: After reset, both output enables and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_wire | input | 1 | 1 selects shared-line read data |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock, idle high |
| spi_sdi | input | 1 | Host-to-slave serial data |
| spi_sdo | output | 1 | Slave-to-host serial data (four-wire mode) |
| spi_sdo_oe | output | 1 | Drive enable for `spi_sdo` |
| spi_sdi_out | output | 1 | Read data driven onto the shared line (three-wire mode) |
| spi_sdi_oe | output | 1 | Drive enable for the shared line |
| rf_addr | output | 6 | Register-file address |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_re | output | 1 | Register-file read strobe, one cycle |
| rf_rdata | input | 8 | Register-file read data for `rf_addr`, sampled at `rf_re` |

## Verification
The embedded assertions check, on every cycle, the properties that follow from the state alone:
- the two strobes exclude each other and last one cycle;
- the address holds in fixed-address frames and steps after an incrementing write;
- read strobes occur only inside read frames;
- the drive enables are exclusive and fall once select is released;
- the output bit changes only on a detected falling edge.

Only the bench scenarios can show the rest: the bit order of the command and data bytes, the data values returned over every address, wrap-around in bursts, abort of a partial byte, and the routing of read data onto the shared line in three-wire mode.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = DATA_W - 2;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int RW_BIT  = DATA_W - 1;
    localparam int INC_BIT = DATA_W - 2;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                chain_d = {chain_q[STAGES-2:0], d};
            end
        end else begin : g_single
            always_comb begin
                chain_d = d;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_n_s,
    input  logic  sclk_s,
    input  logic  sdi_s,
    output addr_t rf_addr,
    output byte_t rf_wdata,
    output logic  rf_we,
    output logic  rf_re,
    output logic  frame_active,
    output logic  rd_phase,
    output logic  sclk_fall
);
    localparam bitcnt_t LAST_BIT = bitcnt_t'(DATA_W - 1);

    typedef struct packed {
        logic    active;
        logic    sclk_prev;
        logic    cmd_done;
        logic    rd;
        logic    inc;
        addr_t   addr;
        bitcnt_t bitcnt;
        byte_t   shreg;
        byte_t   wdata;
        logic    we;
        logic    re;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        active: 1'b0, sclk_prev: 1'b1, cmd_done: 1'b0, rd: 1'b0, inc: 1'b0,
        addr: '0, bitcnt: '0, shreg: '0, wdata: '0, we: 1'b0, re: 1'b0
    };

    ctrl_t ctrl_d, ctrl_q;
    logic  sclk_rise;
    byte_t full_byte;

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.we        = 1'b0;
        ctrl_d.re        = 1'b0;
        ctrl_d.sclk_prev = sclk_s;
        sclk_rise        = ctrl_q.active & sclk_s & ~ctrl_q.sclk_prev;
        full_byte        = {ctrl_q.shreg[DATA_W-2:0], sdi_s};

        // an incrementing write steps the address the cycle after its strobe
        if (ctrl_q.we && ctrl_q.inc) ctrl_d.addr = ctrl_q.addr + 1'b1;

        if (cs_n_s) begin
            ctrl_d.active   = 1'b0;
            ctrl_d.cmd_done = 1'b0;
            ctrl_d.rd       = 1'b0;
            ctrl_d.bitcnt   = '0;
        end else begin
            ctrl_d.active = 1'b1;
            if (sclk_rise) begin
                ctrl_d.shreg  = full_byte;
                ctrl_d.bitcnt = ctrl_q.bitcnt + 1'b1;
                if (ctrl_q.bitcnt == LAST_BIT) begin
                    ctrl_d.bitcnt = '0;
                    if (!ctrl_q.cmd_done) begin
                        ctrl_d.cmd_done = 1'b1;
                        ctrl_d.rd       = full_byte[RW_BIT];
                        ctrl_d.inc      = full_byte[INC_BIT];
                        ctrl_d.addr     = full_byte[ADDR_W-1:0];
                        ctrl_d.re       = full_byte[RW_BIT];
                    end else if (ctrl_q.rd) begin
                        if (ctrl_q.inc) ctrl_d.addr = ctrl_q.addr + 1'b1;
                        ctrl_d.re = 1'b1;
                    end else begin
                        ctrl_d.we    = 1'b1;
                        ctrl_d.wdata = full_byte;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign rf_addr      = ctrl_q.addr;
    assign rf_wdata     = ctrl_q.wdata;
    assign rf_we        = ctrl_q.we;
    assign rf_re        = ctrl_q.re;
    assign frame_active = ctrl_q.active;
    assign rd_phase     = ctrl_q.cmd_done & ctrl_q.rd;
    assign sclk_fall    = ctrl_q.active & ~cs_n_s & ~sclk_s & ctrl_q.sclk_prev;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q.we && ctrl_q.re));                                              // R10
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.we |=> !ctrl_q.we);                                               // R10
    AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.re |=> !ctrl_q.re);                                               // R10
    AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cmd_done && !ctrl_q.inc) |=> $stable(ctrl_q.addr));              // R5
    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.we && ctrl_q.inc) |=> (ctrl_q.addr == $past(ctrl_q.addr) + 1'b1)); // R4
    AST_NO_WE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !ctrl_q.we);                                                  // R7
    AST_RE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.re |-> (ctrl_q.rd && ctrl_q.cmd_done));                           // R6
endmodule

// File: rtl/spi_tx.sv
module spi_tx
    import spi_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_active,
    input  logic  three_wire,
    input  logic  rd_phase,
    input  logic  load,
    input  byte_t load_data,
    input  logic  shift,
    output logic  dout,
    output logic  sdo_oe,
    output logic  sdi_oe
);
    typedef struct packed {
        byte_t shreg;
        logic  dout;
        logic  sdo_oe;
        logic  sdi_oe;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (load) begin
            tx_d.shreg = load_data;
        end else if (shift && rd_phase) begin
            tx_d.dout  = tx_q.shreg[DATA_W-1];
            tx_d.shreg = {tx_q.shreg[DATA_W-2:0], 1'b0};
        end
        tx_d.sdo_oe = frame_active & ~three_wire;
        tx_d.sdi_oe = frame_active & three_wire & rd_phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign dout   = tx_q.dout;
    assign sdo_oe = tx_q.sdo_oe;
    assign sdi_oe = tx_q.sdi_oe;

    AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_q.sdo_oe && tx_q.sdi_oe));                                  // R9
    AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> (!tx_q.sdo_oe && !tx_q.sdi_oe));               // R8
    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(tx_q.dout));                                  // R3
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              three_wire,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic              spi_sdi_out,
    output logic              spi_sdi_oe,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    output logic              rf_re,
    input  logic [DATA_W-1:0] rf_rdata
);
    localparam int          N_SYNC   = 3;
    localparam logic [2:0]  SYNC_RST = 3'b110;

    logic [N_SYNC-1:0] raw_in, synced;
    logic frame_active, rd_phase, sclk_fall, tx_bit;

    assign raw_in = {spi_cs_n, spi_sclk, spi_sdi};

    spi_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    spi_frame_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_s       (synced[2]),
        .sclk_s       (synced[1]),
        .sdi_s        (synced[0]),
        .rf_addr      (rf_addr),
        .rf_wdata     (rf_wdata),
        .rf_we        (rf_we),
        .rf_re        (rf_re),
        .frame_active (frame_active),
        .rd_phase     (rd_phase),
        .sclk_fall    (sclk_fall)
    );

    spi_tx i_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_active (frame_active),
        .three_wire   (three_wire),
        .rd_phase     (rd_phase),
        .load         (rf_re),
        .load_data    (rf_rdata),
        .shift        (sclk_fall),
        .dout         (tx_bit),
        .sdo_oe       (spi_sdo_oe),
        .sdi_oe       (spi_sdi_oe)
    );

    assign spi_sdo     = tx_bit;
    assign spi_sdi_out = tx_bit;
endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 6;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic three_wire = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sclk = 1'b1;
    logic spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_oe, spi_sdi_out, spi_sdi_oe;
    logic [5:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;
    logic rf_we, rf_re;

    logic [7:0] mem [64];
    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];
    logic [5:0] we_addr_log [16];
    logic [7:0] we_data_log [16];
    logic [5:0] re_addr_log [16];
    int checks = 0, fails = 0;
    int we_cnt = 0, re_cnt = 0, both_cnt = 0, wide_cnt = 0;
    int sdo_oe_3w_cnt = 0, sdi_oe_cnt = 0;
    logic prev_we = 1'b0, prev_re = 1'b0, oe_mid = 1'b0, sdi_oe_mid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata = mem[rf_addr];

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .three_wire(three_wire),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
        .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .spi_sdi_out(spi_sdi_out), .spi_sdi_oe(spi_sdi_oe),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
        .rf_rdata(rf_rdata)
    );

    // register-file model and strobe monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_we) begin
                if (we_cnt < 16) begin
                    we_addr_log[we_cnt] = rf_addr;
                    we_data_log[we_cnt] = rf_wdata;
                end
                mem[rf_addr] = rf_wdata;
                we_cnt++;
            end
            if (rf_re) begin
                if (re_cnt < 16) re_addr_log[re_cnt] = rf_addr;
                re_cnt++;
            end
            if (rf_we && rf_re) both_cnt++;
            if ((rf_we && prev_we) || (rf_re && prev_re)) wide_cnt++;
            if (three_wire && spi_sdo_oe) sdo_oe_3w_cnt++;
            if (spi_sdi_oe) sdi_oe_cnt++;
            prev_we = rf_we;
            prev_re = rf_re;
        end
    end

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 37 + salt * 91 + 11) & 255);
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            spi_sclk = 1'b0;
            spi_sdi  = tx[i];
            wait_clks(HALF_CLKS);
            rx[i] = three_wire ? spi_sdi_out : spi_sdo;
            spi_sclk = 1'b1;
            wait_clks(HALF_CLKS);
        end
    endtask

    // command byte {read, incr, addr}; nbytes full bytes then extra_bits partial
    task automatic frame(input logic rd, input logic inc, input logic [5:0] addr,
                         input int nbytes, input int extra_bits);
        logic [7:0] junk;
        we_cnt = 0; re_cnt = 0; sdi_oe_cnt = 0;
        spi_cs_n = 1'b0;
        wait_clks(HALF_CLKS);
        xfer_bits({rd, inc, addr}, 8, junk);
        for (int b = 0; b < nbytes; b++) begin
            xfer_bits(tx_buf[b], 8, rx_buf[b]);
            if (b == 0) begin
                oe_mid     = spi_sdo_oe;
                sdi_oe_mid = spi_sdi_oe;
            end
        end
        if (extra_bits > 0) xfer_bits(8'hA5, extra_bits, junk);
        wait_clks(HALF_CLKS);
        spi_cs_n = 1'b1;
        wait_clks(10);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, WATCHDOG);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'hEE;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(3);
        // R11: idle state after reset
        check_eq("R11", "sdo_oe", int'(spi_sdo_oe), 0);
        check_eq("R11", "sdi_oe", int'(spi_sdi_oe), 0);
        check_eq("R11", "we", int'(rf_we), 0);
        check_eq("R11", "re", int'(rf_re), 0);

        // R1 R2: single write to every address
        for (int a = 0; a < 64; a++) begin
            tx_buf[0] = pat(a, 0);
            frame(1'b0, 1'b0, 6'(a), 1, 0);
            check_eq("R2", "write strobes", we_cnt, 1);
            check_eq("R1", "write addr", int'(we_addr_log[0]), a);
            check_eq("R2", "write data", int'(we_data_log[0]), int'(pat(a, 0)));
            check_eq("R6", "no read strobe in write", re_cnt, 0);
        end
        // R8: idle after frames, driven during a 4-wire frame
        check_eq("R8", "sdo_oe idle", int'(spi_sdo_oe), 0);
        check_eq("R8", "sdo_oe mid frame", int'(oe_mid), 1);

        // R3 R6: single read of every address
        for (int a = 0; a < 64; a++) begin
            tx_buf[0] = 8'h00;
            frame(1'b1, 1'b0, 6'(a), 1, 0);
            check_eq("R3", "read data", int'(rx_buf[0]), int'(pat(a, 0)));
            check_eq("R1", "read addr", int'(re_addr_log[0]), a);
            check_eq("R6", "read strobes", re_cnt, 2);
            check_eq("R3", "no write in read", we_cnt, 0);
        end

        // R4: incrementing write burst wrapping 62,63,0,1
        for (int b = 0; b < 4; b++) tx_buf[b] = pat(b, 1);
        frame(1'b0, 1'b1, 6'd62, 4, 0);
        check_eq("R4", "burst write strobes", we_cnt, 4);
        for (int b = 0; b < 4; b++) begin
            check_eq("R4", "burst write addr", int'(we_addr_log[b]), (62 + b) % 64);
            check_eq("R4", "burst write data", int'(we_data_log[b]), int'(pat(b, 1)));
        end

        // R5: fixed-address write burst
        for (int b = 0; b < 3; b++) tx_buf[b] = pat(b, 2);
        frame(1'b0, 1'b0, 6'd10, 3, 0);
        check_eq("R5", "fixed write strobes", we_cnt, 3);
        for (int b = 0; b < 3; b++)
            check_eq("R5", "fixed write addr", int'(we_addr_log[b]), 10);
        frame(1'b1, 1'b0, 6'd10, 1, 0);
        check_eq("R5", "fixed write last wins", int'(rx_buf[0]), int'(pat(2, 2)));

        // R4 R6: incrementing read burst across the wrap
        frame(1'b1, 1'b1, 6'd62, 4, 0);
        for (int b = 0; b < 4; b++)
            check_eq("R4", "burst read data", int'(rx_buf[b]), int'(pat(b, 1)));
        check_eq("R6", "burst read strobes", re_cnt, 5);
        for (int b = 0; b < 5; b++)
            check_eq("R6", "burst read strobe addr", int'(re_addr_log[b]), (62 + b) % 64);

        // R5 R6: fixed-address read burst
        frame(1'b1, 1'b0, 6'd5, 3, 0);
        for (int b = 0; b < 3; b++)
            check_eq("R5", "fixed read data", int'(rx_buf[b]), int'(pat(5, 0)));
        check_eq("R6", "fixed read strobes", re_cnt, 4);
        for (int b = 0; b < 4; b++)
            check_eq("R5", "fixed read strobe addr", int'(re_addr_log[b]), 5);

        // R7: abort in the middle of the first data byte
        frame(1'b0, 1'b0, 6'd30, 0, 5);
        check_eq("R7", "no strobe on partial byte", we_cnt, 0);
        frame(1'b1, 1'b0, 6'd30, 1, 0);
        check_eq("R7", "register untouched", int'(rx_buf[0]), int'(pat(30, 0)));
        // R7: one full byte written, then the partial byte dropped
        tx_buf[0] = 8'h5A;
        frame(1'b0, 1'b1, 6'd40, 1, 3);
        check_eq("R7", "only full byte written", we_cnt, 1);
        frame(1'b1, 1'b0, 6'd41, 1, 0);
        check_eq("R7", "next register untouched", int'(rx_buf[0]), int'(pat(41, 0)));

        // R9: three-wire read and write
        three_wire = 1'b1;
        wait_clks(4);
        sdo_oe_3w_cnt = 0;
        frame(1'b1, 1'b0, 6'd7, 1, 0);
        check_eq("R9", "3-wire read data", int'(rx_buf[0]), int'(pat(7, 0)));
        check_eq("R9", "shared line driven in read", int'(sdi_oe_mid), 1);
        tx_buf[0] = 8'hC3;
        frame(1'b0, 1'b0, 6'd8, 1, 0);
        check_eq("R9", "shared line idle in write", sdi_oe_cnt, 0);
        check_eq("R9", "3-wire write strobe data", int'(we_data_log[0]), 8'hC3);
        check_eq("R9", "sdo never driven in 3-wire", sdo_oe_3w_cnt, 0);
        check_eq("R8", "shared line idle after frame", int'(spi_sdi_oe), 0);
        three_wire = 1'b0;

        // R10: strobe exclusivity and width across the whole run
        check_eq("R10", "we and re together", both_cnt, 0);
        check_eq("R10", "strobes wider than one cycle", wide_cnt, 0);

        finish_run();
    end
endmodule